// File: doc/BRIEF.md
# Level-Sensitive Banked Interrupt Controller

This block gathers up to 96 level-sensitive interrupt lines into 32-line banks and presents them to a processor as a single interrupt request. Software configures it over a simple 32-bit register port. Each bank has a mask register and two write-one aliases, one that enables lines and one that disables them. A masked pending view shows which enabled lines are currently high.

When any enabled line is high and no earlier report is waiting, the controller latches the number of the lowest such line and raises `irq_o`. That number stays frozen until software writes an acknowledge to the control register. Only then does the controller pick the next winner. A soft reset, started from the configuration register, returns the whole block to its power-on state and shows a done flag when it completes. A per-line level register holds 8 bits of configuration, which software can read back.

Top module: `lvl_irq_hub`

## Requirements
- R1: After `rst_ni` is released: every mask bit is 1, `irq_o` is 0, the status register (0x014) reads 1, the configuration register (0x010) reads 0 and the active-number register (0x040) reads 0.
- R2: The bank-b mask register at 0x084+0x20*b can be written and read directly. Writing to 0x088+0x20*b clears each mask bit that has a 1 in the write data, which enables that line. Writing to 0x08C+0x20*b sets each mask bit that has a 1, which disables that line. Zero bits written to either alias leave the mask bits unchanged.
- R3: The pending register at 0x098+0x20*b reads as the bank's input lines AND NOT its mask.
- R4: When some pending bit is set and no report is outstanding, `irq_o` goes to 1 on the next clock edge. The lowest pending line index is latched and reads in bits [6:0] of 0x040.
- R5: While a report is outstanding, the active number and `irq_o` hold, whatever the inputs do. A control write (0x048) with bit 0 clear has no effect.
- R6: A control write with bit 0 set drops `irq_o` on that edge. If lines are still pending, a new winner is latched on the following edge.
- R7: Writing bit 1 of 0x010 starts a soft reset. Status bit 0 reads 0 for RST_CYCLES cycles and then reads 1. The soft reset restores the R1 state and clears all level registers. Bit 1 of 0x010 always reads 0.
- R8: Bit 0 of 0x010 (autoidle enable) is stored and reads back.
- R9: The register at 0x000 reads {REV_MAJOR in [7:4], REV_MINOR in [3:0]}. The defaults give 0x21.
- R10: The level register of line i at 0x100+4*i stores bits [7:0], and its upper bits read 0. The stored value does not change which line wins: the lowest index always wins.
- R11: Offsets that are not mapped, including misaligned ones, read 0, and writes to them have no effect.
- R12: Read data appears on `rdata_o` at the edge that samples the read request, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Level interrupt lines |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A mask or alias write takes effect on the edge that samples it, and the pending view follows the inputs with no delay. `irq_o` and the active number follow one edge after pending becomes nonzero, and an acknowledge drops `irq_o` on its own edge, with any relatch one edge later. Read data lands one edge after the request. The bench therefore drives inputs on falling edges and samples on the next falling edge after each of these edges. Soft-reset completion is checked by reading status immediately after the request (expected 0) and again after more than RST_CYCLES cycles (expected 1).

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int BANK_W = 32;
  localparam int LVL_W  = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;

  localparam addr_t OFF_REV     = 12'h000;
  localparam addr_t OFF_CFG     = 12'h010;
  localparam addr_t OFF_STAT    = 12'h014;
  localparam addr_t OFF_ACT     = 12'h040;
  localparam addr_t OFF_CTL     = 12'h048;
  localparam addr_t OFF_MASK0   = 12'h084;
  localparam addr_t OFF_MCLR0   = 12'h088;
  localparam addr_t OFF_MSET0   = 12'h08C;
  localparam addr_t OFF_PEND0   = 12'h098;
  localparam int    BANK_STRIDE = 32'h20;
  localparam addr_t OFF_LVL0    = 12'h100;
endpackage

// File: rtl/lvl_irq_bank.sv
module lvl_irq_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wr_mask_i,
  input  logic         wr_en_i,
  input  logic         wr_dis_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '1;
    else if (clr_i)     mask_q <= '1;
    else if (wr_mask_i) mask_q <= wdata_i;
    else if (wr_en_i)   mask_q <= mask_q & ~wdata_i;
    else if (wr_dis_i)  mask_q <= mask_q | wdata_i;
  end

  assign mask_o = mask_q;
  assign pend_o = src_i & ~mask_q;
endmodule

// File: rtl/lvl_irq_pick.sv
module lvl_irq_pick #(
  parameter int N  = 96,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins: scan down so the last hit is the smallest
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lvl_irq_lvl_store.sv
module lvl_irq_lvl_store #(
  parameter int N  = 96,
  parameter int W  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] lvl_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) lvl_q[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < N; i++) lvl_q[i] <= '0;
    end else if (we_i && (int'(wr_idx_i) < N)) begin
      lvl_q[wr_idx_i] <= wdata_i;
    end
  end

  assign rdata_o = (int'(rd_idx_i) < N) ? lvl_q[rd_idx_i] : '0;
endmodule

// File: rtl/lvl_irq_hub.sv
module lvl_irq_hub
  import lvl_irq_pkg::*;
#(
  parameter int N_SRC      = 96,
  parameter int REV_MAJOR  = 2,
  parameter int REV_MINOR  = 1,
  parameter int RST_CYCLES = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_SRC-1:0]      src_i,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  irq_o
);
  localparam int NB    = N_SRC / BANK_W;
  localparam int ID_W  = $clog2(N_SRC);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam int LVL_SPAN = 4 * N_SRC;
  localparam logic [7:0] REV_VAL = {4'(REV_MAJOR), 4'(REV_MINOR)};

  logic wr, rd;
  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  // soft reset sequencer
  logic [CNT_W-1:0] rst_cnt_q;
  logic             soft_clr;
  logic             autoidle_q;
  logic             cfg_wr;
  assign cfg_wr   = wr && (addr_i == OFF_CFG);
  assign soft_clr = (rst_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rst_cnt_q <= '0;
    else if (cfg_wr && wdata_i[1]) rst_cnt_q <= CNT_W'(RST_CYCLES);
    else if (soft_clr)            rst_cnt_q <= rst_cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       autoidle_q <= 1'b0;
    else if (soft_clr) autoidle_q <= 1'b0;
    else if (cfg_wr)   autoidle_q <= wdata_i[0];
  end

  // mask banks
  logic [BANK_W-1:0] mask_w [NB];
  logic [BANK_W-1:0] pend_w [NB];
  logic [N_SRC-1:0]  pend_flat;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam addr_t A_MASK = OFF_MASK0 + addr_t'(b * BANK_STRIDE);
    localparam addr_t A_MCLR = OFF_MCLR0 + addr_t'(b * BANK_STRIDE);
    localparam addr_t A_MSET = OFF_MSET0 + addr_t'(b * BANK_STRIDE);

    lvl_irq_bank #(.W(BANK_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (soft_clr),
      .wr_mask_i (wr && (addr_i == A_MASK)),
      .wr_en_i   (wr && (addr_i == A_MCLR)),
      .wr_dis_i  (wr && (addr_i == A_MSET)),
      .wdata_i   (wdata_i),
      .src_i     (src_i[b*BANK_W +: BANK_W]),
      .mask_o    (mask_w[b]),
      .pend_o    (pend_w[b])
    );
    assign pend_flat[b*BANK_W +: BANK_W] = pend_w[b];
  end

  // arbitration and report latch
  logic            pend_any;
  logic [ID_W-1:0] pick_idx;
  logic            busy_q;
  logic [ID_W-1:0] act_q;
  logic            ack_w;

  lvl_irq_pick #(.N(N_SRC), .IW(ID_W)) u_pick (
    .vec_i (pend_flat),
    .any_o (pend_any),
    .idx_o (pick_idx)
  );

  assign ack_w = wr && (addr_i == OFF_CTL) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      act_q  <= '0;
    end else if (soft_clr) begin
      busy_q <= 1'b0;
      act_q  <= '0;
    end else if (busy_q) begin
      if (ack_w) busy_q <= 1'b0;
    end else if (pend_any) begin
      busy_q <= 1'b1;
      act_q  <= pick_idx;
    end
  end

  assign irq_o = busy_q;

  // per-line level storage
  addr_t             lvl_off;
  logic              lvl_hit;
  logic [ID_W-1:0]   lvl_idx;
  logic [LVL_W-1:0]  lvl_rd;

  assign lvl_off = addr_i - OFF_LVL0;
  assign lvl_hit = (addr_i >= OFF_LVL0) && (int'(lvl_off) < LVL_SPAN) && (lvl_off[1:0] == 2'b00);
  assign lvl_idx = lvl_off[ID_W+1:2];

  lvl_irq_lvl_store #(.N(N_SRC), .W(LVL_W), .IW(ID_W)) u_lvl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (soft_clr),
    .we_i     (wr && lvl_hit),
    .wr_idx_i (lvl_idx),
    .wdata_i  (wdata_i[LVL_W-1:0]),
    .rd_idx_i (lvl_idx),
    .rdata_o  (lvl_rd)
  );

  // read mux
  word_t rd_word;
  always_comb begin
    rd_word = '0;
    unique case (addr_i)
      OFF_REV:  rd_word = word_t'(REV_VAL);
      OFF_CFG:  rd_word = word_t'(autoidle_q);
      OFF_STAT: rd_word = word_t'(!soft_clr);
      OFF_ACT:  rd_word = word_t'(act_q);
      default:  rd_word = '0;
    endcase
    for (int b = 0; b < NB; b++) begin
      if (addr_i == OFF_MASK0 + addr_t'(b * BANK_STRIDE)) rd_word = mask_w[b];
      if (addr_i == OFF_PEND0 + addr_t'(b * BANK_STRIDE)) rd_word = pend_w[b];
    end
    if (lvl_hit) rd_word = word_t'(lvl_rd);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_word;
  end
endmodule

// File: rtl/lvl_irq_hub_chk.sv
module lvl_irq_hub_chk #(
  parameter int N_SRC = 96,
  parameter int ID_W  = $clog2(N_SRC)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            irq_i,
  input logic            ack_i,
  input logic            clr_i,
  input logic            pend_any_i,
  input logic [ID_W-1:0] act_i
);
  assert_rise_on_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(pend_any_i));

  assert_act_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (int'(act_i) < N_SRC));

  assert_hold_until_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !ack_i && !clr_i) |=> (irq_i && $stable(act_i)));

  assert_ack_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && ack_i) |=> !irq_i);

  assert_soft_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !irq_i);
endmodule

bind lvl_irq_hub lvl_irq_hub_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_i      (irq_o),
  .ack_i      (ack_w),
  .clr_i      (soft_clr),
  .pend_any_i (pend_any),
  .act_i      (act_q)
);

// File: tb/lvl_irq_hub_test.sv
module lvl_irq_hub_test;
  localparam int N = 96;
  localparam int NB = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  lvl_irq_hub uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [11:0] a_mask(int b); return 12'(32'h84 + 32'h20 * b); endfunction
  function automatic logic [11:0] a_mclr(int b); return 12'(32'h88 + 32'h20 * b); endfunction
  function automatic logic [11:0] a_mset(int b); return 12'(32'h8C + 32'h20 * b); endfunction
  function automatic logic [11:0] a_pend(int b); return 12'(32'h98 + 32'h20 * b); endfunction
  function automatic logic [11:0] a_lvl(int i);  return 12'(32'h100 + 4 * i); endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] ad, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = ad; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] ad, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = ad;
    @(negedge clk); req = 1'b0;
    d = rdata;
  endtask

  task automatic mask_all();
    for (int b = 0; b < NB; b++) wr(a_mask(b), 32'hFFFF_FFFF);
  endtask

  localparam logic [N-1:0] ALL = '1;
  localparam int NV = 6;
  localparam logic [N-1:0] V_SRC [NV] = '{
    (96'd1 << 5),
    (96'd1 << 40) | (96'd1 << 70),
    (96'd1 << 3) | (96'd1 << 64),
    (96'd1 << 95),
    (96'd1 << 0) | (96'd1 << 33),
    (96'd1 << 10)
  };
  localparam logic [N-1:0] V_EN [NV] = '{
    ALL, ALL, ALL & ~96'hFFFF_FFFF, ALL, ALL, 96'd0
  };
  localparam int V_ID [NV] = '{5, 40, 64, 95, 0, -1};

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    for (int b = 0; b < NB; b++) begin rd(a_mask(b), d); check("R1 mask", d, 32'hFFFF_FFFF); end
    rd(12'h014, d); check("R1 status", d, 1);
    rd(12'h010, d); check("R1 cfg", d, 0);
    rd(12'h040, d); check("R1 active", d, 0);
    rd(12'h000, d); check("R9 revision", d, 32'h21);
    repeat (3) @(negedge clk);
    check("R12 read data held", rdata, 32'h21);

    // vector table: R4 lowest-index pick
    for (int v = 0; v < NV; v++) begin
      mask_all();
      src = V_SRC[v];
      for (int b = 0; b < NB; b++) wr(a_mclr(b), V_EN[v][b*32 +: 32]);
      @(negedge clk);
      check($sformatf("R4 vec%0d irq", v), 32'(irq), (V_ID[v] >= 0) ? 1 : 0);
      if (V_ID[v] >= 0) begin
        rd(12'h040, d); check($sformatf("R4 vec%0d id", v), {25'd0, d[6:0]}, 32'(V_ID[v]));
      end
      src = '0;
      wr(12'h048, 1);
      @(negedge clk);
    end
    mask_all();

    // R2 mask register and aliases
    wr(a_mask(1), 32'h0000_F0F0);
    rd(a_mask(1), d); check("R2 direct", d, 32'h0000_F0F0);
    wr(a_mclr(1), 32'h0000_00F0);
    rd(a_mask(1), d); check("R2 clear alias", d, 32'h0000_F000);
    wr(a_mset(1), 32'h0000_0003);
    rd(a_mask(1), d); check("R2 set alias", d, 32'h0000_F003);

    // R3 pending view
    mask_all();
    src = 96'hABCD << 32;
    wr(a_mask(1), 32'h0000_00FF);
    rd(a_pend(1), d); check("R3 pending", d, 32'h0000_AB00);
    rd(a_pend(0), d); check("R3 pending bank0", d, 0);
    rd(12'h040, d); check("R4 active from pending", d, 40);
    src = '0;
    wr(12'h048, 1);
    mask_all();

    // R5/R6 freeze and acknowledge
    wr(a_mask(0), 0);
    src = (96'd1 << 7) | (96'd1 << 3);
    @(negedge clk);
    check("R4 irq up", 32'(irq), 1);
    rd(12'h040, d); check("R4 lowest", d, 3);
    src[1] = 1'b1;
    repeat (3) @(negedge clk);
    rd(12'h040, d); check("R5 frozen", d, 3);
    wr(12'h048, 0);
    check("R5 zero ctl irq", 32'(irq), 1);
    rd(12'h040, d); check("R5 zero ctl id", d, 3);
    wr(12'h048, 1);
    check("R6 drop on ack", 32'(irq), 0);
    @(negedge clk);
    check("R6 relatch", 32'(irq), 1);
    rd(12'h040, d); check("R6 next id", d, 1);
    src = '0;
    wr(12'h048, 1);
    @(negedge clk);
    check("R6 idle after ack", 32'(irq), 0);

    // R10 level registers
    wr(a_lvl(9), 32'h0000_00FC);
    wr(a_lvl(2), 32'h0000_0004);
    rd(a_lvl(9), d); check("R10 store", d, 32'hFC);
    wr(a_lvl(2), 32'hFFFF_FFFF);
    rd(a_lvl(2), d); check("R10 width", d, 32'hFF);
    wr(a_lvl(2), 32'h0000_0000);
    src = (96'd1 << 9) | (96'd1 << 2);
    @(negedge clk);
    rd(12'h040, d); check("R10 no priority effect", d, 2);
    src = '0;
    wr(12'h048, 1);

    // R11 unmapped
    wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h020, d); check("R11 unmapped 0x20", d, 0);
    rd(12'h044, d); check("R11 unmapped 0x44", d, 0);
    rd(12'h280, d); check("R11 past levels", d, 0);
    rd(12'h125, d); check("R11 misaligned", d, 0);
    rd(a_mask(0), d); check("R11 mask untouched", d, 0);

    // R8 autoidle
    wr(12'h010, 1);
    rd(12'h010, d); check("R8 autoidle", d, 1);

    // R7 soft reset
    wr(a_lvl(5), 32'h55);
    src = 96'd1 << 4;
    @(negedge clk);
    check("R7 pre irq", 32'(irq), 1);
    wr(12'h010, 3);
    rd(12'h014, d); check("R7 busy status", d, 0);
    repeat (8) @(negedge clk);
    rd(12'h014, d); check("R7 done status", d, 1);
    check("R7 irq cleared", 32'(irq), 0);
    rd(a_mask(0), d); check("R7 mask restored", d, 32'hFFFF_FFFF);
    rd(12'h010, d); check("R7 cfg cleared", d, 0);
    rd(a_lvl(5), d); check("R7 level cleared", d, 0);
    rd(12'h040, d); check("R7 active cleared", d, 0);
    src = '0;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule